// File: doc/BRIEF.md
# Single-Bus Hardwired Step Sequencer

This block is the hardwired controller for a processor datapath in which every register shares one internal bus. A three-bit step register walks through timing steps 1 to 7. Combinational output logic turns the current step, the decoded instruction word and the memory-complete input into the bus-driver selects, register load enables, ALU input select, ALU operation and memory read request. Steps 1 to 3 fetch an instruction for every opcode. In that phase the ALU adds the constant 4 to the program counter, and the incremented value returns to the program counter while the memory read is still pending.

Steps 4 to 7 execute. One instruction is fully supported: it adds a memory operand, addressed by a pointer register, into a destination register. Any other opcode ends the instruction at step 4 and does nothing. The steps that consume the memory data register after a read (steps 3 and 6) wait until the memory reports completion. The datapath registers and the memory are outside this block.

Top module: `bus_step_sequencer`

## Requirements
- R1: A synchronous active-high reset places the sequencer in step 1 (`step_o` = 1), and it stays there for as long as reset is held.
- R2: In step 1 the program counter is the only bus driver. The address register and Z load, `mem_read` is high, `alu_sel_y` is 0 (constant 4 on input A) and `alu_op` is 1 (add).
- R3: In step 2, Z drives the bus and the program counter loads. This happens whatever the level of `mem_done`, and the step always advances.
- R4: In step 3 with `mem_done` low, the step holds and no register loads. In step 3 with `mem_done` high, the data register drives the bus and the instruction register loads.
- R5: The instruction word is split into opcode in bits [IR_W-1:2*RW], destination index in bits [2*RW-1:RW] and pointer index in bits [RW-1:0], where RW = log2(NREG). With the default parameters the add opcode is 4'h1.
- R6: In step 4 of an add, general register [pointer] drives the bus, the address register loads and `mem_read` is high.
- R7: In step 5 of an add, general register [destination] drives the bus and Y loads.
- R8: In step 6 with `mem_done` low, the step holds and no register loads. With `mem_done` high, the data register drives the bus, `alu_sel_y` is 1, `alu_op` is 1 (add) and Z loads.
- R9: In step 7, Z drives the bus, general register [destination] loads and `end_o` is high. The next step is 1.
- R10: For any opcode other than add, step 4 asserts only `end_o`. It drives nothing onto the bus and loads nothing, and the next step is 1.
- R11: At most one bit of `bus_drv` is high. Bit 0 is the program counter, bit 1 the data register, bit 2 Z, and bit 3+k general register k.
- R12: `alu_op` is 0 (pass) in every step other than the two add steps (1 and 6). `mem_read` is high only in steps 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_word | input | IR_W | Current instruction register contents |
| mem_done | input | 1 | Memory function complete |
| step_o | output | 3 | Current timing step, 1 to 7 |
| bus_drv | output | 3+NREG | One-hot select of the bus driver |
| pc_in | output | 1 | Program counter load |
| mar_in | output | 1 | Memory address register load |
| ir_in | output | 1 | Instruction register load |
| y_in | output | 1 | Y register load |
| z_in | output | 1 | Z register load |
| gpr_in | output | NREG | General register load enables |
| alu_sel_y | output | 1 | ALU input A: 0 constant 4, 1 Y |
| alu_op | output | 2 | ALU operation: 0 pass, 1 add |
| mem_read | output | 1 | Memory read request |
| end_o | output | 1 | Last step of the instruction |

## Verification
The bench holds `mem_done` low for several cycles in steps 3 and 6. A sequencer that ignored the wait would load a stale word into the instruction register or a wrong sum into Z. It also drives `mem_done` low in step 2, where a sequencer that stalled there would lose a cycle. A second add uses different destination and pointer fields, which exposes register indices that are fixed or swapped. An unsupported opcode shows whether the sequencer ends cleanly at step 4 or wanders into the add steps. A reset applied in mid-execution must return the sequencer to step 1 instead of letting it finish the instruction.

// File: rtl/bss_pkg.sv
package bss_pkg;

   localparam int STEP_W = 3;

   typedef enum logic [STEP_W-1:0] {
      ST_F1 = 3'd1,
      ST_F2 = 3'd2,
      ST_F3 = 3'd3,
      ST_X4 = 3'd4,
      ST_X5 = 3'd5,
      ST_X6 = 3'd6,
      ST_X7 = 3'd7
   } step_e;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1
   } alu_op_e;

   localparam int DRV_PC   = 0;
   localparam int DRV_MDR  = 1;
   localparam int DRV_Z    = 2;
   localparam int DRV_GPR0 = 3;

endpackage

// File: rtl/bss_step_ctr.sv
module bss_step_ctr
   import bss_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              end_i,
   input  logic              stall_i,
   output logic [STEP_W-1:0] step_o
);

   step_e step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= ST_F1;
      end else if (end_i) begin
         step_q <= ST_F1;
      end else if (!stall_i) begin
         step_q <= step_e'(step_q + 3'd1);
      end
   end

   assign step_o = step_q;

endmodule

// File: rtl/bss_op_decode.sv
module bss_op_decode #(
   parameter int          OP_W   = 4,
   parameter int          RW     = 3,
   parameter logic [OP_W-1:0] ADD_OP = 4'h1,
   localparam int         IR_W   = OP_W + 2*RW
) (
   input  logic [IR_W-1:0] ir_word,
   output logic            is_add,
   output logic [RW-1:0]   dst_idx,
   output logic [RW-1:0]   ptr_idx
);

   logic [OP_W-1:0] opcode;

   assign opcode  = ir_word[IR_W-1 -: OP_W];
   assign dst_idx = ir_word[2*RW-1 -: RW];
   assign ptr_idx = ir_word[RW-1:0];
   assign is_add  = (opcode == ADD_OP);

endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
   import bss_pkg::*;
#(
   parameter int NREG = 8,
   parameter int RW   = 3,
   localparam int NDRV = DRV_GPR0 + NREG
) (
   input  logic [STEP_W-1:0] step,
   input  logic              is_add,
   input  logic              mem_done,
   input  logic [RW-1:0]     dst_idx,
   input  logic [RW-1:0]     ptr_idx,
   output logic [NDRV-1:0]   bus_drv,
   output logic              pc_in,
   output logic              mar_in,
   output logic              ir_in,
   output logic              y_in,
   output logic              z_in,
   output logic [NREG-1:0]   gpr_in,
   output logic              alu_sel_y,
   output logic [1:0]        alu_op,
   output logic              mem_read,
   output logic              end_o,
   output logic              stall_o
);

   logic in_f1, in_f2, in_f3, in_x4, in_x5, in_x6, in_x7;
   logic drv_ptr, drv_dst, ld_dst;

   assign in_f1 = (step == ST_F1);
   assign in_f2 = (step == ST_F2);
   assign in_f3 = (step == ST_F3);
   assign in_x4 = (step == ST_X4) && is_add;
   assign in_x5 = (step == ST_X5) && is_add;
   assign in_x6 = (step == ST_X6) && is_add;
   assign in_x7 = (step == ST_X7) && is_add;

   assign stall_o = !mem_done && (in_f3 || in_x6);
   assign end_o   = in_x7 || (!is_add && (step >= ST_X4));

   assign drv_ptr = in_x4;
   assign drv_dst = in_x5;
   assign ld_dst  = in_x7;

   always_comb begin
      bus_drv[DRV_PC]  = in_f1;
      bus_drv[DRV_MDR] = (in_f3 || in_x6) && mem_done;
      bus_drv[DRV_Z]   = in_f2 || in_x7;
   end

   for (genvar k = 0; k < NREG; k++) begin : g_gpr
      assign bus_drv[DRV_GPR0+k] = (drv_ptr && (ptr_idx == RW'(k)))
                                || (drv_dst && (dst_idx == RW'(k)));
      assign gpr_in[k] = ld_dst && (dst_idx == RW'(k));
   end

   assign pc_in     = in_f2;
   assign mar_in    = in_f1 || in_x4;
   assign ir_in     = in_f3 && mem_done;
   assign y_in      = in_x5;
   assign z_in      = in_f1 || (in_x6 && mem_done);
   assign alu_sel_y = in_x6 && mem_done;
   assign alu_op    = (in_f1 || (in_x6 && mem_done)) ? ALU_ADD : ALU_PASS;
   assign mem_read  = in_f1 || in_x4;

endmodule

// File: rtl/bus_step_sequencer.sv
module bus_step_sequencer
   import bss_pkg::*;
#(
   parameter int              NREG   = 8,
   parameter int              OP_W   = 4,
   parameter logic [OP_W-1:0] ADD_OP = 4'h1,
   localparam int             RW     = $clog2(NREG),
   localparam int             IR_W   = OP_W + 2*RW,
   localparam int             NDRV   = DRV_GPR0 + NREG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IR_W-1:0]   ir_word,
   input  logic              mem_done,
   output logic [STEP_W-1:0] step_o,
   output logic [NDRV-1:0]   bus_drv,
   output logic              pc_in,
   output logic              mar_in,
   output logic              ir_in,
   output logic              y_in,
   output logic              z_in,
   output logic [NREG-1:0]   gpr_in,
   output logic              alu_sel_y,
   output logic [1:0]        alu_op,
   output logic              mem_read,
   output logic              end_o
);

   initial begin
      assert (NREG >= 2) else $fatal(1, "NREG must be at least 2");
      assert (OP_W >= 1) else $fatal(1, "OP_W must be at least 1");
   end

   logic          is_add;
   logic [RW-1:0] dst_idx;
   logic [RW-1:0] ptr_idx;
   logic          stall;

   bss_step_ctr u_ctr (
      .clk     (clk),
      .rst     (rst),
      .end_i   (end_o),
      .stall_i (stall),
      .step_o  (step_o)
   );

   bss_op_decode #(
      .OP_W   (OP_W),
      .RW     (RW),
      .ADD_OP (ADD_OP)
   ) u_dec (
      .ir_word (ir_word),
      .is_add  (is_add),
      .dst_idx (dst_idx),
      .ptr_idx (ptr_idx)
   );

   bss_strobe_gen #(
      .NREG (NREG),
      .RW   (RW)
   ) u_gen (
      .step      (step_o),
      .is_add    (is_add),
      .mem_done  (mem_done),
      .dst_idx   (dst_idx),
      .ptr_idx   (ptr_idx),
      .bus_drv   (bus_drv),
      .pc_in     (pc_in),
      .mar_in    (mar_in),
      .ir_in     (ir_in),
      .y_in      (y_in),
      .z_in      (z_in),
      .gpr_in    (gpr_in),
      .alu_sel_y (alu_sel_y),
      .alu_op    (alu_op),
      .mem_read  (mem_read),
      .end_o     (end_o),
      .stall_o   (stall)
   );

endmodule

// File: rtl/bus_step_sequencer_chk.sv
module bus_step_sequencer_chk #(
   parameter int NREG = 8,
   localparam int NDRV = 3 + NREG
) (
   input logic            clk,
   input logic            rst,
   input logic            mem_done,
   input logic [2:0]      step_o,
   input logic [NDRV-1:0] bus_drv,
   input logic            ir_in,
   input logic            z_in,
   input logic [NREG-1:0] gpr_in,
   input logic            mem_read,
   input logic            end_o
);

   // R1
   reset_step_chk: assert property (@(posedge clk) rst |=> (step_o == 3'd1));

   // R9
   end_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      end_o |=> (step_o == 3'd1));

   // R4
   fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step_o == 3'd3 && !mem_done) |=> (step_o == 3'd3));

   // R4
   fetch_noload_chk: assert property (@(posedge clk) disable iff (rst)
      (step_o == 3'd3 && !mem_done) |-> !ir_in);

   // R8
   exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step_o == 3'd6 && !mem_done) |=> (step_o == 3'd6));

   // R8
   exec_noload_chk: assert property (@(posedge clk) disable iff (rst)
      (step_o == 3'd6 && !mem_done) |-> (!z_in && gpr_in == '0));

   // R11
   bus_single_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bus_drv));

   // R12
   read_step_chk: assert property (@(posedge clk) disable iff (rst)
      mem_read |-> (step_o == 3'd1 || step_o == 3'd4));

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (step_o == 3'd2) |=> (step_o == 3'd3));

endmodule

bind bus_step_sequencer bus_step_sequencer_chk #(.NREG(NREG)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_done (mem_done),
   .step_o   (step_o),
   .bus_drv  (bus_drv),
   .ir_in    (ir_in),
   .z_in     (z_in),
   .gpr_in   (gpr_in),
   .mem_read (mem_read),
   .end_o    (end_o)
);

// File: tb/bus_step_sequencer_bench.sv
`timescale 1ns/1ps
module bus_step_sequencer_bench;

   localparam int NREG = 8;
   localparam int IR_W = 10;
   localparam int NDRV = 11;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [IR_W-1:0]   ir_word = '0;
   logic              mem_done = 1'b0;
   logic [2:0]        step_o;
   logic [NDRV-1:0]   bus_drv;
   logic              pc_in, mar_in, ir_in, y_in, z_in;
   logic [NREG-1:0]   gpr_in;
   logic              alu_sel_y;
   logic [1:0]        alu_op;
   logic              mem_read, end_o;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   bus_step_sequencer u_bus_step_sequencer (
      .clk(clk), .rst(rst), .ir_word(ir_word), .mem_done(mem_done),
      .step_o(step_o), .bus_drv(bus_drv), .pc_in(pc_in), .mar_in(mar_in),
      .ir_in(ir_in), .y_in(y_in), .z_in(z_in), .gpr_in(gpr_in),
      .alu_sel_y(alu_sel_y), .alu_op(alu_op), .mem_read(mem_read), .end_o(end_o)
   );

   typedef struct packed {
      logic [9:0]  ir;
      logic        done;
      logic [2:0]  step;
      logic [10:0] drv;
      logic [4:0]  ld;    // {pc,mar,ir,y,z}
      logic [7:0]  gin;
      logic        sel;
      logic [1:0]  alu;   // R12: 0 pass, 1 add
      logic        rd;
      logic        en;
   } vec_t;

   // R5: add words 10'h04B (dst 1, ptr 3) and 10'h06A (dst 5, ptr 2); 10'h1C0 is opcode 7
   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      '{10'h04B, 1'b0, 3'd1, 11'h001, 5'b01001, 8'h00, 1'b0, 2'd1, 1'b1, 1'b0},
      '{10'h04B, 1'b0, 3'd2, 11'h004, 5'b10000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b0, 3'd3, 11'h000, 5'b00000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b0, 3'd3, 11'h000, 5'b00000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b1, 3'd3, 11'h002, 5'b00100, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b0, 3'd4, 11'h040, 5'b01000, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0},
      '{10'h04B, 1'b0, 3'd5, 11'h010, 5'b00010, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b0, 3'd6, 11'h000, 5'b00000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h04B, 1'b1, 3'd6, 11'h002, 5'b00001, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0},
      '{10'h04B, 1'b1, 3'd7, 11'h004, 5'b00000, 8'h02, 1'b0, 2'd0, 1'b0, 1'b1},
      '{10'h1C0, 1'b1, 3'd1, 11'h001, 5'b01001, 8'h00, 1'b0, 2'd1, 1'b1, 1'b0},
      '{10'h1C0, 1'b1, 3'd2, 11'h004, 5'b10000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h1C0, 1'b1, 3'd3, 11'h002, 5'b00100, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h1C0, 1'b1, 3'd4, 11'h000, 5'b00000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1},
      '{10'h06A, 1'b1, 3'd1, 11'h001, 5'b01001, 8'h00, 1'b0, 2'd1, 1'b1, 1'b0},
      '{10'h06A, 1'b1, 3'd2, 11'h004, 5'b10000, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h06A, 1'b1, 3'd3, 11'h002, 5'b00100, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h06A, 1'b1, 3'd4, 11'h020, 5'b01000, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0},
      '{10'h06A, 1'b1, 3'd5, 11'h100, 5'b00010, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0},
      '{10'h06A, 1'b1, 3'd6, 11'h002, 5'b00001, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0},
      '{10'h06A, 1'b1, 3'd7, 11'h004, 5'b00000, 8'h20, 1'b0, 2'd0, 1'b0, 1'b1},
      '{10'h06A, 1'b1, 3'd1, 11'h001, 5'b01001, 8'h00, 1'b0, 2'd1, 1'b1, 1'b0}
   };

   function automatic string step_tag(input logic [2:0] s, input logic [9:0] ir);
      case (s)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return (ir[9:6] == 4'h1) ? "R6" : "R10";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_vec(input vec_t v);
      logic [33:0] got, exp;
      got = {step_o, bus_drv, pc_in, mar_in, ir_in, y_in, z_in, gpr_in,
             alu_sel_y, alu_op, mem_read, end_o};
      exp = {v.step, v.drv, v.ld, v.gin, v.sel, v.alu, v.rd, v.en};
      check(got === exp, step_tag(v.step, v.ir), "strobes", 64'(got), 64'(exp));
      // R11: at most one bus driver
      check($onehot0(bus_drv), "R11", "bus one-hot", 64'(bus_drv), 64'(v.drv));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset holds step 1
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(step_o == 3'd1 && !end_o, "R1", "reset step", 64'(step_o), 64'd1);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         ir_word  = TBL[i].ir;
         mem_done = TBL[i].done;
         #1;
         check_vec(TBL[i]);
         @(negedge clk);
      end
      // now in step 2 of third add; advance to step 5
      repeat (3) @(negedge clk);
      check(step_o == 3'd5, "R7", "mid-exec step", 64'(step_o), 64'd5);
      // R1: reset in mid execution
      rst = 1'b1;
      @(negedge clk);
      check(step_o == 3'd1 && bus_drv == 11'h001, "R1", "reset mid-exec",
            64'({step_o, bus_drv}), 64'({3'd1, 11'h001}));
      rst = 1'b0;
      // R4: long fetch stall, R3: step 2 advances with mem_done low
      mem_done = 1'b0;
      @(negedge clk);
      check(step_o == 3'd2, "R3", "step2 no stall", 64'(step_o), 64'd2);
      @(negedge clk);
      repeat (20) @(negedge clk);
      check(step_o == 3'd3 && !ir_in, "R4", "long stall",
            64'({step_o, ir_in}), 64'({3'd3, 1'b0}));
      mem_done = 1'b1;
      #1;
      check(ir_in == 1'b1, "R4", "release load", 64'(ir_in), 64'd1);
      @(negedge clk);
      check(step_o == 3'd4 && bus_drv == 11'h020, "R6", "after stall",
            64'({step_o, bus_drv}), 64'({3'd4, 11'h020}));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule